// File: doc/BRIEF.md
# Asynchronous SRAM Access Strobe Sequencer

This block drives the control strobes for one chip-select area of external asynchronous SRAM. It takes a single read or write request, carrying an address, write data and byte enables. It then runs one bus access of programmable shape. The outputs are an active-low chip select, an active-low read strobe, one active-low write strobe per byte lane, an active-low write-direction signal, and a one-cycle completion pulse. While an access is running, `req_ready` is low.

The shape of each access comes from a small configuration register, which is sampled at the moment a request is accepted. It sets four things:

- the number of read wait cycles;
- the number of write wait cycles, where one code falls back to the read count;
- the setup delay from chip select to strobe, counted in half cycles;
- a byte-select mode that swaps which signal carries the strobe timing and which signal spans the whole access.

The half-cycle part of the setup delay is produced by launching the strobes from falling-edge flops.

Top module: `sram_strobe_gen`

## Requirements
- R1: Configuration bits [3:0] give the read wait count W (0..15); a read strobe stays asserted for W+1 clock cycles.
- R2: Configuration bits [6:4] hold the write wait code; codes 1 to 7 give code-1 write wait cycles (0 to 6), and the write strobe lasts that count plus one cycle.
- R3: A write wait code of 0 makes a write use the read wait count from bits [3:0].
- R4: Configuration bits [9:8] hold the setup code S; the strobe falls S+0.5 clock cycles after chip select falls, and chip select falls on the clock edge that accepts the request.
- R5: With the mode bit (bit 12) at 0, each enabled write lane's strobe follows the strobe timing, and the direction signal `rdwr_n` is low for the whole time chip select is low during a write.
- R6: With the mode bit at 1, each enabled lane's `we_n` is low for the whole time chip select is low, on reads and on writes; `rdwr_n` is low only during the strobe timing, and only on writes.
- R7: `rd_n` is low with the strobe timing on reads only. The strobe rises half a cycle after the wait period ends, and chip select rises one cycle after the wait period ends. `done` is high for exactly the one cycle that starts when chip select rises.
- R8: `req_ready` is high only when the block is idle, which is from the cycle after `done` onward. A request presented while `req_ready` is low is ignored, and `mem_addr` and `mem_wdata` hold the accepted values while chip select is low.
- R9: The configuration is sampled when a request is accepted; a configuration write during an access does not change that access.
- R10: Unused configuration bits read back as 0 whatever is written.
- R11: After reset all strobes are high, `done` is low, `req_ready` is high, and the configuration reads as 0. That configuration gives a 0.5-cycle setup, no waits and mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes also switch on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration read-back |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| req_be | input | DW/8 | Byte-lane enables |
| req_ready | output | 1 | Block idle, request can be accepted |
| mem_addr | output | AW | Address to memory, held during access |
| mem_wdata | output | DW | Write data to memory, held during access |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | DW/8 | Per-lane write strobes, active low |
| rdwr_n | output | 1 | Write direction, active low |
| done | output | 1 | One-cycle access completion pulse |

## Verification
The assertions assume that a request is accepted only while `req_ready` is high. They also assume that reset is held for at least one rising and one falling edge, so that the falling-edge strobe flops start from a known value. The stimulus meets both conditions. It raises requests only in the idle state, except for the deliberate hold-off probes. Those probes present a request while the block is busy and withdraw it before `req_ready` returns. Configuration writes come from the same idle-state sequences, apart from one write placed inside an access to show that it has no effect on that access.

// File: rtl/sram_tim_pkg.sv
// Shared types for the SRAM strobe sequencer.
// Assumes: the configuration layout below is the software-visible one.
package sram_tim_pkg;

    localparam int RW_BITS  = 4;   // read wait field width
    localparam int WW_BITS  = 3;   // write wait code width
    localparam int SU_BITS  = 2;   // setup code width
    localparam int CNT_W    = RW_BITS;

    localparam int RW_LSB   = 0;
    localparam int WW_LSB   = 4;
    localparam int SU_LSB   = 8;
    localparam int BM_BIT   = 12;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic               bmode;
        logic [SU_BITS-1:0] setup;
        logic [WW_BITS-1:0] wwait;
        logic [RW_BITS-1:0] rwait;
    } tim_cfg_t;

endpackage

// File: rtl/sram_cfg_reg.sv
// Timing configuration register.
// Holds read wait, write wait code, setup code and byte-select mode.
// Unused bit positions are not stored and read back as zero.
// Assumes: one write per cycle; synchronous active-low reset clears to zero.
module sram_cfg_reg
    import sram_tim_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output tim_cfg_t         cfg_o,
    output logic [REG_W-1:0] cfg_rdata
);

    tim_cfg_t cfg_q;

    // Capture the used fields on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.rwait <= cfg_wdata[RW_LSB +: RW_BITS];
            cfg_q.wwait <= cfg_wdata[WW_LSB +: WW_BITS];
            cfg_q.setup <= cfg_wdata[SU_LSB +: SU_BITS];
            cfg_q.bmode <= cfg_wdata[BM_BIT];
        end
    end

    // Rebuild the read-back word with unused bits at zero
    always_comb begin
        cfg_rdata                    = '0;
        cfg_rdata[RW_LSB +: RW_BITS] = cfg_q.rwait;
        cfg_rdata[WW_LSB +: WW_BITS] = cfg_q.wwait;
        cfg_rdata[SU_LSB +: SU_BITS] = cfg_q.setup;
        cfg_rdata[BM_BIT]            = cfg_q.bmode;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/sram_cycle_fsm.sv
// Access sequencer: IDLE -> SETUP (S cycles) -> STROBE (W+1 cycles)
// -> HOLD (1) -> DONE (1) -> IDLE.
// Latches the request and the effective timing at acceptance.
// Assumes: requests are only taken while req_ready is high.
module sram_cycle_fsm
    import sram_tim_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int NB = DW/8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tim_cfg_t      cfg,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [NB-1:0] req_be,
    output logic          req_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [NB-1:0] be_q,
    output logic          wr_q,
    output logic          bmode_q,
    output logic          cs_act,
    output logic          strobe_ph,
    output logic          done
);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wait_q;
    logic [CNT_W-1:0] wait_sel;
    logic             accept;

    assign accept = req_valid && (state == ST_IDLE);

    // Pick the wait count for this request; write code 0 borrows the read count
    always_comb begin
        if (req_write && (cfg.wwait != '0))
            wait_sel = CNT_W'(cfg.wwait - 1'b1);
        else
            wait_sel = cfg.rwait;
    end

    // Sequence state and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    if (cfg.setup == '0) begin
                        state <= ST_STROBE;
                        cnt   <= wait_sel;
                    end else begin
                        state <= ST_SETUP;
                        cnt   <= CNT_W'(cfg.setup - 1'b1);
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        state <= ST_STROBE;
                        cnt   <= wait_q;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (cnt == '0) state <= ST_HOLD;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_HOLD: state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request and timing capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
            be_q      <= '0;
            wr_q      <= 1'b0;
            bmode_q   <= 1'b0;
            wait_q    <= '0;
        end else if (accept) begin
            mem_addr  <= req_addr;
            mem_wdata <= req_wdata;
            be_q      <= req_be;
            wr_q      <= req_write;
            bmode_q   <= cfg.bmode;
            wait_q    <= wait_sel;
        end
    end

    // Status decodes
    assign req_ready = (state == ST_IDLE);
    assign cs_act    = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    assign strobe_ph = (state == ST_STROBE);
    assign done      = (state == ST_DONE);

    // R7: completion lasts one cycle and follows the hold cycle
    a_r7_done_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_HOLD) && !cs_act)
        else $error("done not preceded by hold");

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    // R8: address and data do not move while the chip is selected
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act)) |-> ($stable(mem_addr) && $stable(mem_wdata)))
        else $error("address or data changed during access");

    // R9: latched timing does not move during a busy period
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(wait_q) && $stable(bmode_q)))
        else $error("timing changed mid-access");

endmodule

// File: rtl/sram_strobe_out.sv
// Falling-edge strobe stage and mode-dependent output mapping.
// Delays the strobe phase by half a cycle so setup becomes S+0.5 cycles.
// Assumes: inputs change only on rising edges.
module sram_strobe_out #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_ph,
    input  logic          cs_act,
    input  logic          wr_q,
    input  logic          bmode_q,
    input  logic [NB-1:0] be_q,
    output logic          rd_n,
    output logic [NB-1:0] we_n,
    output logic          rdwr_n
);

    logic str_q;

    // Half-cycle shifted strobe timing
    always_ff @(negedge clk) begin
        if (!rst_n) str_q <= 1'b0;
        else        str_q <= strobe_ph;
    end

    // Read strobe for read accesses only
    assign rd_n = !(str_q && !wr_q);

    // Direction signal: whole write cycle in mode 0, strobe timing in mode 1
    assign rdwr_n = bmode_q ? !(str_q && wr_q) : !(cs_act && wr_q);

    // Per-lane write strobes
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign we_n[i] = bmode_q ? !(cs_act && be_q[i])
                                 : !(str_q && wr_q && be_q[i]);
    end

    // R7: a strobe is never active outside chip select
    a_r7_rd_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> cs_act)
        else $error("read strobe outside chip select");

    a_r5_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n != {NB{1'b1}}) |-> cs_act)
        else $error("write strobe outside chip select");

endmodule

// File: rtl/sram_strobe_gen.sv
// Top level of the SRAM access strobe sequencer.
// Joins the configuration register, access sequencer and strobe stage.
// Assumes: single chip-select area, requests honoured only when req_ready.
module sram_strobe_gen
    import sram_tim_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int REG_W = 16,
    localparam int NB   = DW/8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [NB-1:0]    req_be,
    output logic             req_ready,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             cs_n,
    output logic             rd_n,
    output logic [NB-1:0]    we_n,
    output logic             rdwr_n,
    output logic             done
);

    tim_cfg_t      cfg;
    logic [NB-1:0] be_q;
    logic          wr_q, bmode_q, cs_act, strobe_ph;

    sram_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg),
        .cfg_rdata (cfg_rdata)
    );

    sram_cycle_fsm #(.AW(AW), .DW(DW), .NB(NB)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .req_ready (req_ready),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .be_q      (be_q),
        .wr_q      (wr_q),
        .bmode_q   (bmode_q),
        .cs_act    (cs_act),
        .strobe_ph (strobe_ph),
        .done      (done)
    );

    sram_strobe_out #(.NB(NB)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_ph (strobe_ph),
        .cs_act    (cs_act),
        .wr_q      (wr_q),
        .bmode_q   (bmode_q),
        .be_q      (be_q),
        .rd_n      (rd_n),
        .we_n      (we_n),
        .rdwr_n    (rdwr_n)
    );

    // Chip select follows the active phases of the sequencer
    assign cs_n = !cs_act;

    // R8: never ready while the chip is selected
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready)
        else $error("ready during access");

endmodule

// File: tb/sim_sram_strobe_gen.sv
// Bench: behavioural half-cycle timeline model compared every half cycle.
module sim_sram_strobe_gen;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NB = DW/8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NB-1:0] req_be = '0;
    logic          req_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          cs_n, rd_n, rdwr_n, done;
    logic [NB-1:0] we_n;

    int checks = 0;
    int errors = 0;

    // model copy of the configuration
    int m_rw = 0, m_ww = 0, m_su = 0, m_bm = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_strobe_gen #(.AW(AW), .DW(DW), .REG_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n), .rdwr_n(rdwr_n), .done(done)
    );

    task automatic chk(input string req, input string what, input int k,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s k=%0d got %h exp %h", req, what, k, got, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        m_rw = int'(v[3:0]);
        m_ww = int'(v[6:4]);
        m_su = int'(v[9:8]);
        m_bm = int'(v[12]);
    endtask

    // One access, checked every half cycle from the accepting edge
    task automatic run_txn(input logic wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic [NB-1:0] be,
                           input bit holdoff, input bit midcfg,
                           input logic [15:0] midval, input string tag);
        int s, w, kmax;
        bit cs, st, dn, rdy;
        logic [NB-1:0] exp_we;
        logic exp_rdwr;
        s = m_su;
        if (wr && m_ww != 0) w = m_ww - 1;
        else                 w = m_rw;
        kmax = 2*(s+w+3) + 2;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        for (int k = 0; k < kmax; k++) begin
            #(k == 0 ? CLK_PERIOD/4 : CLK_PERIOD/2);
            cs  = (k < 2*(s+w+2));
            st  = (k >= 2*s+1) && (k < 2*(s+w+1)+1);
            dn  = (k >= 2*(s+w+2)) && (k < 2*(s+w+3));
            rdy = (k >= 2*(s+w+3));
            for (int i = 0; i < NB; i++)
                exp_we[i] = (m_bm != 0) ? !(cs && be[i]) : !(st && wr && be[i]);
            exp_rdwr = (m_bm != 0) ? !(st && wr) : !(cs && wr);
            chk({tag, " R4"}, "cs_n", k, {31'b0, cs_n}, {31'b0, !cs});
            chk({tag, " R7"}, "rd_n", k, {31'b0, rd_n}, {31'b0, !(st && !wr)});
            chk({tag, (m_bm != 0) ? " R6" : " R5"}, "we_n", k, 32'(we_n), 32'(exp_we));
            chk({tag, (m_bm != 0) ? " R6" : " R5"}, "rdwr_n", k, {31'b0, rdwr_n}, {31'b0, exp_rdwr});
            chk({tag, " R7"}, "done", k, {31'b0, done}, {31'b0, dn});
            chk({tag, " R8"}, "ready", k, {31'b0, req_ready}, {31'b0, rdy});
            if (cs) begin
                chk({tag, " R8"}, "mem_addr", k, 32'(mem_addr), 32'(a));
                if (wr) chk({tag, " R8"}, "mem_wdata", k, 32'(mem_wdata), 32'(d));
            end
            if (k == 0) begin
                if (holdoff) begin
                    req_addr = ~a; req_wdata = ~d;
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (k == 1 && midcfg) begin
                cfg_we = 1'b1; cfg_wdata = midval;
            end
            if (k == 2) req_valid = 1'b0;
            if (k == 3) cfg_we = 1'b0;
        end
        if (midcfg) begin
            m_rw = int'(midval[3:0]); m_ww = int'(midval[6:4]);
            m_su = int'(midval[9:8]); m_bm = int'(midval[12]);
        end
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        // R11 reset state
        chk("R11", "cs_n", 0, {31'b0, cs_n}, 32'd1);
        chk("R11", "rd_n", 0, {31'b0, rd_n}, 32'd1);
        chk("R11", "we_n", 0, 32'(we_n), 32'(2'b11));
        chk("R11", "rdwr_n", 0, {31'b0, rdwr_n}, 32'd1);
        chk("R11", "done", 0, {31'b0, done}, 32'd0);
        chk("R11", "ready", 0, {31'b0, req_ready}, 32'd1);
        chk("R11", "cfg", 0, 32'(cfg_rdata), 32'd0);

        // R11 reset configuration: 0.5 setup, no waits, mode 0
        run_txn(1'b0, 16'h1234, 16'h0, 2'b11, 1'b0, 1'b0, 16'h0, "r11_rd");
        run_txn(1'b1, 16'h0042, 16'hBEEF, 2'b01, 1'b0, 1'b0, 16'h0, "r11_wr");

        // R10 unused bits read as zero
        write_cfg(16'hFFFF);
        #1;
        chk("R10", "cfg", 0, 32'(cfg_rdata), 32'h137F);

        // R1 / R4 read, wait 3, setup 2
        write_cfg(16'h0203);
        run_txn(1'b0, 16'hA5A5, 16'h0, 2'b11, 1'b0, 1'b0, 16'h0, "R1 R4");
        // R3 write code 0 falls back to read wait 3
        run_txn(1'b1, 16'h5A5A, 16'h1357, 2'b11, 1'b0, 1'b0, 16'h0, "R3");
        // R2 write code 1 -> no wait, setup 1, mode 0
        write_cfg(16'h0117);
        run_txn(1'b1, 16'h0101, 16'hC0DE, 2'b10, 1'b0, 1'b0, 16'h0, "R2 R5");
        // R2 write code 7 -> 6 waits, setup 3, mode 1
        write_cfg(16'h1371);
        run_txn(1'b1, 16'h0F0F, 16'h2468, 2'b01, 1'b0, 1'b0, 16'h0, "R2 R6");
        // R6 read in mode 1
        write_cfg(16'h1002);
        run_txn(1'b0, 16'h7777, 16'h0, 2'b10, 1'b0, 1'b0, 16'h0, "R6_rd");
        // R1 long read wait 15, setup 3
        write_cfg(16'h030F);
        run_txn(1'b0, 16'hFFFE, 16'h0, 2'b11, 1'b0, 1'b0, 16'h0, "R1_max");
        // R8 request held off while busy
        write_cfg(16'h0122);
        run_txn(1'b1, 16'h3C3C, 16'h9999, 2'b11, 1'b1, 1'b0, 16'h0, "R8_hold");
        // R9 mid-access configuration write has no effect on this access
        run_txn(1'b0, 16'h4444, 16'h0, 2'b11, 1'b0, 1'b1, 16'h1305, "R9");
        // R9 next access uses the new configuration
        run_txn(1'b1, 16'h4446, 16'h8181, 2'b11, 1'b0, 1'b0, 16'h0, "R9_next");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule